// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a configuration-space access requester and the outbound address path of a root port. Each request names a bus, device, function and register offset, and says whether it is a read or a write. One cycle later the block presents the local address to access. It also presents the settings for the outbound translation region: the configuration type code, the packed target field, and whether the target must be reloaded and the region enabled.

The root port's own register space is reached directly for bus 0, with no translation. Every other bus goes through a 1 MB window that sits at the top of a 16 MB aperture. Device numbers that cannot exist on the two nearest buses are refused. A refused read yields all ones, and a refused write is dropped.

Top module: `cfgx_xlate`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high. While `out_valid` is low, every other output is zero.
- R2: An accepted request on bus 0 or bus 1 gives `out_kind` = 4 (type 0). An accepted request on bus 2 or above gives `out_kind` = 5 (type 1).
- R3: An accepted bus-0 request sets `out_bypass`. Its `out_addr` is LOCAL_BASE (default 0x01FFC000) OR the aligned offset. `out_target_load`, `out_region_en` and `out_target` are all zero.
- R4: An accepted request on any other bus sets `out_target_load` and `out_region_en`. Its `out_target` is {bus[7:0], dev[4:0], fn[2:0], 16'h0}, with the bus in bits 31:24, the device in 23:19 and the function in 18:16. Its `out_addr` is 0x01F00000, the last 1 MB of a 16 MB aperture at 0x01000000, OR the aligned offset.
- R5: The 12-bit register offset is dword aligned: bits 1:0 of `out_addr` are always zero, and offset bits 11:2 appear unchanged in `out_addr` bits 11:2.
- R6: On bus 0 only devices 0 and 1 are accepted. On bus 1 only device 0 is accepted. On every other bus all 32 devices are accepted. A refused request sets `out_error`.
- R7: A refused read returns `out_rdata` = 0xFFFFFFFF. Every other response returns `out_rdata` = 0.
- R8: An accepted write sets `out_wr_en` and forwards the write data on `out_wdata`. A refused write leaves `out_wr_en`, `out_target_load`, `out_region_en` and `out_wdata` at zero. `out_write` echoes the direction of the request.
- R9: After synchronous reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_off | input | 12 | Register byte offset |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| out_valid | output | 1 | Response strobe |
| out_error | output | 1 | Request refused |
| out_bypass | output | 1 | Direct local register access |
| out_kind | output | 5 | Translation region type code |
| out_addr | output | 32 | Local access address |
| out_target | output | 32 | Packed target field for the region |
| out_target_load | output | 1 | Reload the region target |
| out_region_en | output | 1 | Region enable (bit 31 of its second control word) |
| out_write | output | 1 | Direction echo |
| out_wr_en | output | 1 | Write is to be issued |
| out_wdata | output | 32 | Forwarded write data |
| out_rdata | output | 32 | Fill value for refused reads |

## Verification
Requests are sent on bus 0 with devices 0, 1 and 2. This separates the direct path from the refusal check at its boundary. Bus 1 with devices 0 and 3 does the same for the tighter limit on that bus. Bus 2 and bus 255, using extreme device, function and offset values, show the type change and the placement of each target field. Offsets with their low bits set show the alignment. Back-to-back requests and idle gaps show that the strobe timing and the zeroing of idle outputs are kept. Each case is run as both a read and a write, which separates the all-ones fill from write dropping.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int OFF_W  = 12;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int KIND_W = 5;
    localparam int TGT_LO = 16;

    localparam logic [KIND_W-1:0] KIND_TYPE0 = 5'd4;
    localparam logic [KIND_W-1:0] KIND_TYPE1 = 5'd5;

    typedef struct packed {
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FN_W-1:0]   fn;
        logic [OFF_W-1:0]  off;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } cfg_req_t;

    typedef struct packed {
        logic              error;
        logic              bypass;
        logic [KIND_W-1:0] kind;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       target;
        logic              target_load;
        logic              region_en;
        logic              write;
        logic              wr_en;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } cfg_resp_t;

    function automatic logic [OFF_W-1:0] dword_align(input logic [OFF_W-1:0] o);
        return {o[OFF_W-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/cfgx_devcheck.sv
module cfgx_devcheck
    import cfgx_pkg::*;
#(
    parameter int BUS0_DEVS = 2,
    parameter int BUS1_DEVS = 1
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    output logic             ok
);
    localparam logic [DEV_W-1:0] LIM0 = DEV_W'(BUS0_DEVS);
    localparam logic [DEV_W-1:0] LIM1 = DEV_W'(BUS1_DEVS);

    always_comb begin
        if (bus == '0)
            ok = (dev < LIM0);
        else if (bus == BUS_W'(1))
            ok = (dev < LIM1);
        else
            ok = 1'b1;
    end
endmodule

// File: rtl/cfgx_encode.sv
module cfgx_encode
    import cfgx_pkg::*;
#(
    parameter int TYPE1_MIN_BUS = 2
) (
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FN_W-1:0]   fn,
    output logic [KIND_W-1:0] kind,
    output logic [31:0]       target
);
    localparam logic [BUS_W-1:0] T1_BUS = BUS_W'(TYPE1_MIN_BUS);

    always_comb begin
        kind   = (bus < T1_BUS) ? KIND_TYPE0 : KIND_TYPE1;
        target = {bus, dev, fn, {TGT_LO{1'b0}}};
    end
endmodule

// File: rtl/cfgx_addrgen.sv
module cfgx_addrgen
    import cfgx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LOCAL_BASE = 32'h01FF_C000,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h01F0_0000
) (
    input  logic              bypass,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - OFF_W;

    always_comb begin
        addr = (bypass ? LOCAL_BASE : WIN_BASE) | {{PAD_W{1'b0}}, dword_align(off)};
    end
endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
    import cfgx_pkg::*;
#(
    parameter logic [31:0] LOCAL_BASE    = 32'h01FF_C000,
    parameter logic [31:0] APERTURE_BASE = 32'h0100_0000,
    parameter logic [31:0] APERTURE_SIZE = 32'h0100_0000,
    parameter logic [31:0] WINDOW_SIZE   = 32'h0010_0000,
    parameter int          BUS0_DEVS     = 2,
    parameter int          BUS1_DEVS     = 1,
    parameter int          TYPE1_MIN_BUS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [7:0]  req_bus,
    input  logic [4:0]  req_dev,
    input  logic [2:0]  req_fn,
    input  logic [11:0] req_off,
    input  logic        req_write,
    input  logic [31:0] req_wdata,
    output logic        out_valid,
    output logic        out_error,
    output logic        out_bypass,
    output logic [4:0]  out_kind,
    output logic [31:0] out_addr,
    output logic [31:0] out_target,
    output logic        out_target_load,
    output logic        out_region_en,
    output logic        out_write,
    output logic        out_wr_en,
    output logic [31:0] out_wdata,
    output logic [31:0] out_rdata
);
    localparam logic [31:0] WIN_BASE = APERTURE_BASE + APERTURE_SIZE - WINDOW_SIZE;

    cfg_req_t    req;
    cfg_resp_t   resp_d, resp_q;
    logic        valid_q;
    logic        dev_ok;
    logic        is_bus0;
    logic [KIND_W-1:0] kind;
    logic [31:0] target;
    logic [ADDR_W-1:0] addr;

    assign req = '{bus: req_bus, dev: req_dev, fn: req_fn, off: req_off,
                   write: req_write, wdata: req_wdata};
    assign is_bus0 = (req.bus == '0);

    cfgx_devcheck #(.BUS0_DEVS(BUS0_DEVS), .BUS1_DEVS(BUS1_DEVS)) u_chk (
        .bus(req.bus), .dev(req.dev), .ok(dev_ok)
    );

    cfgx_encode #(.TYPE1_MIN_BUS(TYPE1_MIN_BUS)) u_enc (
        .bus(req.bus), .dev(req.dev), .fn(req.fn), .kind(kind), .target(target)
    );

    cfgx_addrgen #(.LOCAL_BASE(LOCAL_BASE), .WIN_BASE(WIN_BASE)) u_addr (
        .bypass(is_bus0), .off(req.off), .addr(addr)
    );

    always_comb begin
        resp_d = '0;
        if (req_valid) begin
            resp_d.write = req.write;
            if (!dev_ok) begin
                resp_d.error = 1'b1;
                resp_d.rdata = req.write ? '0 : '1;
            end else begin
                resp_d.bypass      = is_bus0;
                resp_d.kind        = kind;
                resp_d.addr        = addr;
                resp_d.target      = is_bus0 ? '0 : target;
                resp_d.target_load = !is_bus0;
                resp_d.region_en   = !is_bus0;
                resp_d.wr_en       = req.write;
                resp_d.wdata       = req.write ? req.wdata : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            resp_q  <= '0;
        end else begin
            valid_q <= req_valid;
            resp_q  <= resp_d;
        end
    end

    assign out_valid       = valid_q;
    assign out_error       = resp_q.error;
    assign out_bypass      = resp_q.bypass;
    assign out_kind        = resp_q.kind;
    assign out_addr        = resp_q.addr;
    assign out_target      = resp_q.target;
    assign out_target_load = resp_q.target_load;
    assign out_region_en   = resp_q.region_en;
    assign out_write       = resp_q.write;
    assign out_wr_en       = resp_q.wr_en;
    assign out_wdata       = resp_q.wdata;
    assign out_rdata       = resp_q.rdata;

endmodule

// File: rtl/cfgx_xlate_chk.sv
module cfgx_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [7:0]  req_bus,
    input logic [4:0]  req_dev,
    input logic        req_write,
    input logic        out_valid,
    input logic        out_error,
    input logic        out_bypass,
    input logic [4:0]  out_kind,
    input logic [31:0] out_addr,
    input logic [31:0] out_target,
    input logic        out_target_load,
    input logic        out_region_en,
    input logic        out_write,
    input logic        out_wr_en,
    input logic [31:0] out_rdata
);
    assert_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && out_addr == 32'h0 && !out_error));
    assert_kind_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_error && out_target[31:24] >= 8'd2) |-> out_kind == 5'd5);
    assert_bypass_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_bypass) |-> (!out_target_load && !out_region_en));
    assert_align_R5: assert property (@(posedge clk) disable iff (rst)
        out_addr[1:0] == 2'b00);
    assert_bus0dev_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_bus == 8'd0 && req_dev > 5'd1) |=> out_error);
    assert_bus1dev_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_bus == 8'd1 && req_dev != 5'd0) |=> out_error);
    assert_fill_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_error && !out_write) |-> out_rdata == 32'hFFFF_FFFF);
    assert_drop_R8: assert property (@(posedge clk) disable iff (rst)
        out_error |-> (!out_wr_en && !out_target_load && !out_region_en));
    assert_dir_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_write == $past(req_write));
endmodule

bind cfgx_xlate cfgx_xlate_chk u_xlate_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bus(req_bus),
    .req_dev(req_dev), .req_write(req_write), .out_valid(out_valid),
    .out_error(out_error), .out_bypass(out_bypass), .out_kind(out_kind),
    .out_addr(out_addr), .out_target(out_target),
    .out_target_load(out_target_load), .out_region_en(out_region_en),
    .out_write(out_write), .out_wr_en(out_wr_en), .out_rdata(out_rdata)
);

// File: tb/tb_cfgx_xlate.sv
`timescale 1ns/1ps
module tb_cfgx_xlate;
    logic clk = 1'b0;
    logic rst;
    logic req_valid;
    logic [7:0] req_bus;
    logic [4:0] req_dev;
    logic [2:0] req_fn;
    logic [11:0] req_off;
    logic req_write;
    logic [31:0] req_wdata;
    logic out_valid, out_error, out_bypass, out_target_load, out_region_en;
    logic out_write, out_wr_en;
    logic [4:0] out_kind;
    logic [31:0] out_addr, out_target, out_wdata, out_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    cfgx_xlate dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bus(req_bus),
        .req_dev(req_dev), .req_fn(req_fn), .req_off(req_off),
        .req_write(req_write), .req_wdata(req_wdata), .out_valid(out_valid),
        .out_error(out_error), .out_bypass(out_bypass), .out_kind(out_kind),
        .out_addr(out_addr), .out_target(out_target),
        .out_target_load(out_target_load), .out_region_en(out_region_en),
        .out_write(out_write), .out_wr_en(out_wr_en), .out_wdata(out_wdata),
        .out_rdata(out_rdata)
    );

    // expected response for the request driven in the previous cycle
    logic [31:0] e_valid, e_err, e_byp, e_kind, e_addr, e_tgt, e_tl, e_ren,
                 e_wr, e_wen, e_wd, e_rd;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic model(input bit v, input int bus, input int dev, input int fn,
                         input int off, input bit wr, input logic [31:0] wd);
        bit ok;
        e_valid = v; e_err = 0; e_byp = 0; e_kind = 0; e_addr = 0; e_tgt = 0;
        e_tl = 0; e_ren = 0; e_wr = 0; e_wen = 0; e_wd = 0; e_rd = 0;
        if (v) begin
            e_wr = wr;
            if (bus == 0) ok = (dev <= 1);
            else if (bus == 1) ok = (dev == 0);
            else ok = 1;
            if (!ok) begin
                e_err = 1;
                e_rd = wr ? 32'h0 : 32'hFFFF_FFFF;
            end else begin
                e_kind = (bus < 2) ? 4 : 5;
                if (bus == 0) begin
                    e_byp = 1;
                    e_addr = 32'h01FF_C000 + (off / 4) * 4;
                end else begin
                    e_tl = 1; e_ren = 1;
                    e_tgt = bus * 32'h0100_0000 + dev * 32'h0008_0000 + fn * 32'h0001_0000;
                    e_addr = 32'h0100_0000 + 32'h0100_0000 - 32'h0010_0000 + (off / 4) * 4;
                end
                if (wr) begin e_wen = 1; e_wd = wd; end
            end
        end
    endtask

    task automatic compare();
        chk("R1", "valid", out_valid, e_valid);
        chk("R6", "error", out_error, e_err);
        chk("R2", "kind", out_kind, e_kind);
        chk("R3", "bypass", out_bypass, e_byp);
        chk("R4", "target", out_target, e_tgt);
        chk("R4", "target_load", out_target_load, e_tl);
        chk("R4", "region_en", out_region_en, e_ren);
        chk("R5", "addr", out_addr, e_addr);
        chk("R7", "rdata", out_rdata, e_rd);
        chk("R8", "write", out_write, e_wr);
        chk("R8", "wr_en", out_wr_en, e_wen);
        chk("R8", "wdata", out_wdata, e_wd);
    endtask

    // drive at negedge, check one negedge later (one register stage)
    task automatic step(input bit v, input int bus, input int dev, input int fn,
                        input int off, input bit wr, input logic [31:0] wd);
        req_valid = v;
        req_bus = 8'(bus); req_dev = 5'(dev); req_fn = 3'(fn);
        req_off = 12'(off); req_write = wr; req_wdata = wd;
        @(negedge clk);
        model(v, bus, dev, fn, off, wr, wd);
        compare();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; req_valid = 0; req_bus = 0; req_dev = 0; req_fn = 0;
        req_off = 0; req_write = 0; req_wdata = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        model(0, 0, 0, 0, 0, 0, 0);
        chk("R9", "valid", out_valid, 0);
        chk("R9", "addr", out_addr, 0);
        chk("R9", "rdata", out_rdata, 0);
        compare();
        rst = 0;
        step(0, 0, 0, 0, 0, 0, 0);
        // R3 R5 bus 0 direct, unaligned offsets
        step(1, 0, 0, 0, 12'h013, 0, 0);
        step(1, 0, 1, 7, 12'hFFF, 1, 32'hDEAD_BEEF);
        // R6 R7 R8 bus 0 boundary device
        step(1, 0, 2, 0, 12'h004, 0, 0);
        step(1, 0, 31, 3, 12'h008, 1, 32'h1234_5678);
        step(0, 0, 0, 0, 0, 0, 0);
        // R4 R2 bus 1
        step(1, 1, 0, 5, 12'h102, 0, 0);
        step(1, 1, 0, 0, 12'hFFF, 1, 32'hA5A5_5A5A);
        step(1, 1, 1, 0, 12'h000, 0, 0);
        step(1, 1, 3, 2, 12'h010, 1, 32'hFFFF_0000);
        // R2 type 1 on bus 2 and above, extreme fields
        step(1, 2, 31, 7, 12'h3FD, 0, 0);
        step(1, 255, 31, 7, 12'hFFF, 1, 32'h0000_0001);
        step(1, 128, 16, 4, 12'h801, 0, 0);
        step(1, 3, 0, 1, 12'h000, 1, 32'hCAFE_F00D);
        // R1 idle gap and back-to-back
        step(0, 2, 5, 1, 12'h010, 1, 32'h1);
        step(0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 40; i++)
            step(i % 3 != 2, (i * 7) % 4, (i * 5) % 32, i % 8, (i * 37) % 4096,
                 i % 2 == 1, 32'(i * 32'h0101_0101));
        step(0, 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule